// File: doc/BRIEF.md
# Shared Atomic Word Memory with Per-Port Reservations

This block is a small word-addressed memory that two or more requesters share. Each requester owns one request port. A port can issue a plain load, a plain store, an atomic swap, a load-reserved, or a store-conditional. Every port has its own valid/ready handshake. A round-robin arbiter accepts one request per cycle. Because each accepted request reads and writes the array in that single cycle, no other port can act between the read half and the write half of a swap or conditional store. Neither operation can be torn.

Each port holds one reservation: a valid flag and a word address. A load-reserved sets it. The port's own store-conditional always consumes it. Any successful write from a different port to the same word removes it. A lock that spins on swap, or a retry loop of load-reserved followed by store-conditional, can therefore be built on top. The response for each accepted request comes back on the port's own response lane in the following cycle.

Top module: `atomem_top`

## Requirements
- R1: After reset, no response is valid, no port is ready while it is idle, every word reads as zero, and no port holds a reservation.
- R2: A load (opcode 0) returns the word at its address. A store (opcode 1) writes its data and returns zero. In both cases the response is valid in the cycle after the request is accepted.
- R3: A swap (opcode 2) writes the port's data into the addressed word and returns the previous contents as one indivisible step.
- R4: At most one port is ready in any cycle, and ready is given only to a port that requests. When several ports keep requesting, grants rotate so that the port granted last goes last. Two swaps to the same word that are presented in the same cycle complete one after the other: exactly one of them returns the old value, and the other returns the first one's data.
- R5: A load-reserved (opcode 3) returns the word at its address and records a reservation for that port on that address.
- R6: A store-conditional (opcode 4) to the port's reserved address writes its data and returns status 0.
- R7: A successful write (store, swap or successful store-conditional) by one port to a word clears every other port's reservation on that word. A write to another word leaves the reservation intact.
- R8: A store-conditional returns status 1 and writes nothing when its address differs from the reserved address or when the port has no reservation.
- R9: A store-conditional always clears the issuing port's reservation, whether it succeeds or fails.
- R10: A new load-reserved replaces the port's earlier reservation.
- R11: A response is valid only on the lane of the port accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Request strobe, one bit per port |
| req_ready | output | NPORTS | Grant, one bit per port; a request is accepted when valid and ready are both high |
| req_op | input | 3*NPORTS | Opcode per port (0 load, 1 store, 2 swap, 3 load-reserved, 4 store-conditional) |
| req_addr | input | ADDR_W*NPORTS | Word address per port |
| req_wdata | input | DATA_W*NPORTS | Write data per port (64-bit doubleword by default) |
| rsp_valid | output | NPORTS | Response strobe per port, one cycle after acceptance |
| rsp_data | output | DATA_W*NPORTS | Read value, or status for a store-conditional, per port |

## Verification
The hardest case to reach from the ports is a genuine collision: two swaps to one word in the same cycle, or another port's write that lands between a load-reserved and its store-conditional. The bench raises two swaps on the same clock edge. It then retires each port only when that port's response shows up, which lets the arbiter order the pair. For reservations, a directed sequence puts a foreign store between the reserve and the conditional. A model-checked random phase confined to four addresses then makes such interleavings frequent.

// File: rtl/atomem_pkg.sv
package atomem_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_LR    = 3'd3,
        OP_SC    = 3'd4
    } op_e;

    localparam int unsigned OP_W = 3;

    // Unconditional writers; a store-conditional writes only on success.
    function automatic logic op_plain_write(op_e op);
        return (op == OP_STORE) || (op == OP_SWAP);
    endfunction

    // Operations that hand the previous word contents back to the port.
    function automatic logic op_returns_old(op_e op);
        return (op == OP_LOAD) || (op == OP_SWAP) || (op == OP_LR);
    endfunction

endpackage

// File: rtl/atomem_rr_arb.sv
module atomem_rr_arb #(
    parameter int unsigned N  = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    logic [IW-1:0] ptr_q;

    always_comb begin
        int unsigned c;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int unsigned k = 0; k < N; k++) begin
            c = (int'(ptr_q) + k) % N;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (gnt_any) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));  // R4

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
                gnt[i] |-> req[i]);  // R4
            AST_RR_LAST: assert property (@(posedge clk) disable iff (rst)
                (gnt[i] && $past(gnt[i])) |-> ($countones(req) == 1));  // R4
        end
    endgenerate

endmodule

// File: rtl/atomem_resv.sv
module atomem_resv
    import atomem_pkg::*;
#(
    parameter int unsigned N      = 2,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [IW-1:0]     acc_idx,
    input  op_e               acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              sc_pass,
    output logic              wr_en
);

    logic [N-1:0]      rv_q;
    logic [ADDR_W-1:0] ra_q [N];

    assign sc_pass = rv_q[acc_idx] && (ra_q[acc_idx] == acc_addr);
    assign wr_en   = acc && (op_plain_write(acc_op) || ((acc_op == OP_SC) && sc_pass));

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q <= '0;
            for (int i = 0; i < N; i++) ra_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (acc && (int'(acc_idx) == i)) begin
                    if (acc_op == OP_LR) begin
                        rv_q[i] <= 1'b1;
                        ra_q[i] <= acc_addr;
                    end else if (acc_op == OP_SC) begin
                        rv_q[i] <= 1'b0;
                    end
                end else if (wr_en && (ra_q[i] == acc_addr)) begin
                    rv_q[i] <= 1'b0;
                end
            end
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_SC_DROPS_OWN: assert property (@(posedge clk) disable iff (rst)
                (acc && (int'(acc_idx) == i) && (acc_op == OP_SC)) |=> !rv_q[i]);  // R9
            AST_LR_RECORDS: assert property (@(posedge clk) disable iff (rst)
                (acc && (int'(acc_idx) == i) && (acc_op == OP_LR))
                |=> (rv_q[i] && (ra_q[i] == $past(acc_addr))));  // R10
            AST_FOREIGN_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (wr_en && (int'(acc_idx) != i) && (ra_q[i] == acc_addr)) |=> !rv_q[i]);  // R7
        end
    endgenerate

endmodule

// File: rtl/atomem_top.sv
module atomem_top
    import atomem_pkg::*;
#(
    parameter int unsigned NPORTS = 2,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned DEPTH = 1 << ADDR_W,
    localparam int unsigned IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        req_valid,
    output logic [NPORTS-1:0]        req_ready,
    input  logic [NPORTS*OP_W-1:0]   req_op,
    input  logic [NPORTS*ADDR_W-1:0] req_addr,
    input  logic [NPORTS*DATA_W-1:0] req_wdata,
    output logic [NPORTS-1:0]        rsp_valid,
    output logic [NPORTS*DATA_W-1:0] rsp_data
);

    logic [NPORTS-1:0] gnt;
    logic [IW-1:0]     gnt_idx;
    logic              acc;
    op_e               sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] result;
    logic              sc_pass;
    logic              wr_en;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [NPORTS-1:0] rsp_valid_q;
    logic [DATA_W-1:0] rsp_q [NPORTS];

    atomem_rr_arb #(.N(NPORTS)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (acc)
    );

    assign req_ready = gnt;
    assign sel_op    = op_e'(req_op[int'(gnt_idx)*OP_W +: OP_W]);
    assign sel_addr  = req_addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata[int'(gnt_idx)*DATA_W +: DATA_W];
    assign old_word  = mem_q[sel_addr];

    atomem_resv #(.N(NPORTS), .ADDR_W(ADDR_W)) resv_i (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_idx  (gnt_idx),
        .acc_op   (sel_op),
        .acc_addr (sel_addr),
        .sc_pass  (sc_pass),
        .wr_en    (wr_en)
    );

    always_comb begin
        if (op_returns_old(sel_op))  result = old_word;
        else if (sel_op == OP_SC)    result = sc_pass ? '0 : DATA_W'(1);
        else                         result = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (wr_en) begin
            mem_q[sel_addr] <= sel_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= '0;
            for (int i = 0; i < NPORTS; i++) rsp_q[i] <= '0;
        end else begin
            rsp_valid_q <= gnt;
            for (int i = 0; i < NPORTS; i++) begin
                if (gnt[i]) rsp_q[i] <= result;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;

    generate
        for (genvar i = 0; i < NPORTS; i++) begin : g_rsp
            assign rsp_data[i*DATA_W +: DATA_W] = rsp_q[i];
            AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
                rsp_valid[i] |-> $past(req_valid[i] && req_ready[i]));  // R11
        end
    endgenerate

    AST_SWAP_LANDS: assert property (@(posedge clk) disable iff (rst)
        (acc && (sel_op == OP_SWAP)) |=> (mem_q[$past(sel_addr)] == $past(sel_wdata)));  // R3

    AST_SC_FAIL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (acc && (sel_op == OP_SC) && !sc_pass) |=> (mem_q[$past(sel_addr)] == $past(old_word)));  // R8

endmodule

// File: tb/atomem_top_tb_top.sv
module atomem_top_tb_top;
    import atomem_pkg::*;

    localparam int N  = 2;
    localparam int AW = 4;
    localparam int DW = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_ready;
    logic [N*3-1:0]    req_op = '0;
    logic [N*AW-1:0]   req_addr = '0;
    logic [N*DW-1:0]   req_wdata = '0;
    logic [N-1:0]      rsp_valid;
    logic [N*DW-1:0]   rsp_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [DW-1:0] ref_mem [16];
    bit            ref_v [N];
    int            ref_a [N];

    always #5 clk = ~clk;

    atomem_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(int p, op_e op, int a, logic [DW-1:0] d);
        req_valid[p]         = 1'b1;
        req_op[p*3 +: 3]     = op;
        req_addr[p*AW +: AW] = AW'(a);
        req_wdata[p*DW +: DW] = d;
    endtask

    // Expected response from the requirements; updates the reference state.
    task automatic model(int p, op_e op, int a, logic [DW-1:0] d, output logic [DW-1:0] exp);
        bit wrote = 0;
        case (op)
            OP_LOAD:  exp = ref_mem[a];
            OP_STORE: begin exp = '0; wrote = 1; end
            OP_SWAP:  begin exp = ref_mem[a]; wrote = 1; end
            OP_LR:    begin exp = ref_mem[a]; ref_v[p] = 1; ref_a[p] = a; end
            default: begin
                if (ref_v[p] && ref_a[p] == a) begin exp = '0; wrote = 1; end
                else exp = 64'd1;
                ref_v[p] = 0;
            end
        endcase
        if (wrote) begin
            ref_mem[a] = d;
            for (int q = 0; q < N; q++)
                if (q != p && ref_v[q] && ref_a[q] == a) ref_v[q] = 0;
        end
    endtask

    // One request on one port, alone; checks latency and lane, returns the data.
    task automatic op1(int p, op_e op, int a, logic [DW-1:0] d, string tag,
                       output logic [DW-1:0] r);
        logic [DW-1:0] exp;
        model(p, op, a, d, exp);
        @(negedge clk);
        drive(p, op, a, d);
        @(negedge clk);
        chk({tag, " R11 lane"}, DW'(rsp_valid), DW'(1 << p));
        r = rsp_data[p*DW +: DW];
        chk({tag, " model"}, r, exp);
        req_valid[p] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [DW-1:0] got [N];
        int order [N];
        int nresp;
        void'($urandom(32'h5eed_0042));
        for (int a = 0; a < 16; a++) ref_mem[a] = '0;
        for (int q = 0; q < N; q++) begin ref_v[q] = 0; ref_a[q] = 0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid", DW'(rsp_valid), '0);
        chk("R1 req_ready", DW'(req_ready), '0);
        op1(0, OP_LOAD, 5, '0, "R1 zero word", r);
        chk("R1 zero", r, '0);
        op1(1, OP_SC, 6, 64'hAA, "R1 no resv", r);
        chk("R1 sc fails", r, 64'd1);

        op1(0, OP_STORE, 3, 64'h1111_2222_3333_4444, "R2 store", r);
        chk("R2 store rsp", r, '0);
        op1(1, OP_LOAD, 3, '0, "R2 load", r);
        chk("R2 load", r, 64'h1111_2222_3333_4444);

        op1(1, OP_SWAP, 3, 64'hDEAD_BEEF, "R3 swap", r);
        chk("R3 swap old", r, 64'h1111_2222_3333_4444);
        op1(0, OP_LOAD, 3, '0, "R3 after", r);
        chk("R3 new", r, 64'hDEAD_BEEF);

        // R4 rotation with both ports requesting continuously
        @(negedge clk);
        drive(0, OP_LOAD, 1, '0);
        drive(1, OP_LOAD, 2, '0);
        for (int k = 0, prev = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R4 one grant", DW'($countones(rsp_valid)), 64'd1);
            if (k > 0) chk("R4 rotate", DW'(rsp_valid == prev), '0);
            prev = rsp_valid;
        end
        req_valid = '0;
        @(negedge clk);

        // R4 simultaneous swaps on word 7
        @(negedge clk);
        drive(0, OP_SWAP, 7, 64'hA0A0);
        drive(1, OP_SWAP, 7, 64'hB1B1);
        nresp = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            for (int q = 0; q < N; q++) begin
                if (rsp_valid[q]) begin
                    got[q] = rsp_data[q*DW +: DW];
                    if (nresp < N) order[nresp] = q;
                    nresp++;
                    req_valid[q] = 1'b0;
                end
            end
        end
        chk("R4 two responses", DW'(nresp), 64'd2);
        chk("R4 first sees old", got[order[0]], '0);
        chk("R4 second sees first", got[order[1]], (order[0] == 0) ? 64'hA0A0 : 64'hB1B1);
        ref_mem[7] = (order[1] == 0) ? 64'hA0A0 : 64'hB1B1;
        op1(0, OP_LOAD, 7, '0, "R3 race final", r);

        op1(0, OP_LR, 8, '0, "R5 lr", r);
        chk("R5 lr value", r, '0);
        op1(0, OP_SC, 8, 64'h5C5C, "R6 sc", r);
        chk("R6 sc ok", r, '0);
        op1(1, OP_LOAD, 8, '0, "R6 written", r);
        chk("R6 value", r, 64'h5C5C);

        op1(0, OP_LR, 8, '0, "R7 lr", r);
        op1(1, OP_STORE, 8, 64'h7777, "R7 foreign", r);
        op1(0, OP_SC, 8, 64'h9999, "R7 sc", r);
        chk("R7 sc fails", r, 64'd1);
        op1(1, OP_LOAD, 8, '0, "R7 kept", r);
        chk("R7 foreign value", r, 64'h7777);
        op1(0, OP_LR, 9, '0, "R7 lr2", r);
        op1(1, OP_STORE, 10, 64'h1010, "R7 other word", r);
        op1(0, OP_SC, 9, 64'h0909, "R7 sc2", r);
        chk("R7 untouched resv", r, '0);

        op1(1, OP_LR, 4, '0, "R8 lr", r);
        op1(1, OP_SC, 5, 64'h5555, "R8 sc wrong addr", r);
        chk("R8 status", r, 64'd1);
        op1(0, OP_LOAD, 5, '0, "R8 no write", r);
        chk("R8 word 5", r, '0);

        op1(0, OP_LR, 11, '0, "R9 lr", r);
        op1(0, OP_SC, 11, 64'hB0B0, "R9 sc1", r);
        chk("R9 first", r, '0);
        op1(0, OP_SC, 11, 64'hC0C0, "R9 sc2", r);
        chk("R9 second fails", r, 64'd1);

        op1(1, OP_LR, 12, '0, "R10 lr a", r);
        op1(1, OP_LR, 13, '0, "R10 lr b", r);
        op1(1, OP_SC, 13, 64'hD13, "R10 sc b", r);
        chk("R10 newest ok", r, '0);
        op1(1, OP_LR, 12, '0, "R10 lr a2", r);
        op1(1, OP_LR, 13, '0, "R10 lr b2", r);
        op1(1, OP_SC, 12, 64'hD12, "R10 sc a", r);
        chk("R10 older fails", r, 64'd1);

        // Random phase on four words to force reservation interleavings (R5-R9)
        for (int n = 0; n < 400; n++) begin
            int p;
            int a;
            op_e op;
            p  = int'($urandom % N);
            a  = int'($urandom % 4);
            op = op_e'($urandom % 5);
            op1(p, op, a, {$urandom, $urandom}, "RND R7 R9", r);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule